// File: doc/BRIEF.md
# Partitioned Cache Victim Selector

This block picks the way to evict when a set-associative cache must allocate a line on a fill. The requester ID, the physical address and the tag state of every way in the addressed set (valid, dirty, lock and use bits) are presented with a request strobe. One clock later the block returns four things: the set index, the chosen way, whether that way holds dirty data that must be written back, and which use bits the tag array should clear.

Eviction is limited in two ways. Each processor core has its own way mask, and all hardware agents share one separate mask. A mask bit of 1 keeps that requester out of that way, and a mask bit of 0 lets it evict there. Lines with the lock bit set are never replaced. The masks affect only allocation, so lookups and hits in any way are not restricted. When no way is left open, the block raises a no-victim flag so that the fill does not allocate.

The masks are written and read through a small register port. A write that would set every bit of a mask is refused, so each requester always keeps at least one way it may evict from.

Top module: `cache_victim_sel`

## Requirements
- R1: After reset every mask is all zeros, and `out_valid`, `victim_valid`, `no_victim`, `victim_dirty`, `use_clr_mask` and `set_index` are all zero.
- R2: A write with `cfg_we` high stores `cfg_wdata` as a mask at the clock edge. A `cfg_sel` value of 0 to NUM_CORES-1 selects that core's mask. Any larger value selects the single shared hardware-agent mask. `cfg_rdata` shows the mask chosen by `cfg_sel`, and `req_id` uses the same mapping to choose the mask for a request.
- R3: A write whose data has every bit set is refused and leaves the mask unchanged, so `cfg_rdata` is never all ones.
- R4: A way is eligible only if its mask bit for the requester is 0 and its lock bit is 0. The reported victim is always an eligible way. A way that is blocked in every mask is therefore never chosen.
- R5: If any eligible way is invalid, the victim is the lowest-numbered eligible invalid way, and `use_clr_mask` is zero.
- R6: Otherwise, if any eligible way has its use bit clear, the victim is the lowest-numbered eligible way whose use bit is clear, and `use_clr_mask` is zero.
- R7: Otherwise, when every eligible way is valid with its use bit set, the victim is the lowest-numbered eligible way, and `use_clr_mask` equals the set of eligible ways.
- R8: With no eligible way, `no_victim` is 1, `victim_valid` is 0, `victim_way` is 0, `victim_dirty` is 0 and `use_clr_mask` is zero. Whenever `out_valid` is high, exactly one of `victim_valid` and `no_victim` is 1.
- R9: `victim_dirty` is 1 exactly when the chosen way is both valid and dirty.
- R10: All results appear one clock after `req_valid`, with `out_valid` high for that cycle. `set_index` equals `req_paddr[7 +: SET_BITS]`, which corresponds to 128-byte lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mask write strobe |
| cfg_sel | input | ID_W | Mask select: a core number, or any larger value for the hardware mask |
| cfg_wdata | input | NUM_WAYS | Mask write data (bit 1 blocks eviction) |
| cfg_rdata | output | NUM_WAYS | Mask chosen by cfg_sel |
| req_valid | input | 1 | Victim request strobe |
| req_id | input | ID_W | Requester ID, mapped to a mask the same way as cfg_sel |
| req_paddr | input | PADDR_W | Physical address of the fill |
| way_valid | input | NUM_WAYS | Valid bit of each way in the set |
| way_dirty | input | NUM_WAYS | Dirty bit of each way |
| way_lock | input | NUM_WAYS | Lock bit of each way |
| way_use | input | NUM_WAYS | Use bit of each way |
| out_valid | output | 1 | Results valid, one clock after req_valid |
| set_index | output | SET_BITS | Set index taken from the address |
| victim_valid | output | 1 | A victim way was chosen |
| victim_way | output | WAY_W | Chosen way |
| victim_dirty | output | 1 | Chosen way is valid and dirty |
| no_victim | output | 1 | No way may be evicted |
| use_clr_mask | output | NUM_WAYS | Use bits the tag array should clear |

## Verification
The sweep case (R7) is the hardest to reach with random stimulus. It needs every eligible way to be valid with its use bit set, while the mask and the lock bits still leave at least one way open. The no-victim case (R8) is nearly as rare, because it needs the mask and the locks together to cover every way. The bench therefore weights its random tag state heavily toward valid, used lines. It also drives directed requests that lock all but one open way, that combine a sparse mask with complementary locks, and that switch between a core mask and the hardware mask on the same tag state.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
   localparam int LINE_SHIFT = 7;

   typedef enum logic [1:0] {
      PICK_NONE    = 2'd0,
      PICK_INVALID = 2'd1,
      PICK_UNUSED  = 2'd2,
      PICK_SWEEP   = 2'd3
   } pick_e;
endpackage

// File: rtl/cvs_lowest.sv
module cvs_lowest #(
   parameter int W   = 8,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/cvs_mask_regs.sv
module cvs_mask_regs #(
   parameter int NUM_WAYS  = 8,
   parameter int NUM_CORES = 4,
   parameter int ID_W      = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [ID_W-1:0]     cfg_sel,
   input  logic [NUM_WAYS-1:0] cfg_wdata,
   output logic [NUM_WAYS-1:0] cfg_rdata,
   input  logic [ID_W-1:0]     req_id,
   output logic [NUM_WAYS-1:0] req_mask
);
   localparam int NUM_REQ = NUM_CORES + 1;
   localparam int HW_SLOT = NUM_CORES;

   logic [NUM_REQ-1:0][NUM_WAYS-1:0] mask_all;
   logic                             wr_ok;

   function automatic int slot_of(input logic [ID_W-1:0] id);
      return (int'(id) < NUM_CORES) ? int'(id) : HW_SLOT;
   endfunction

   assign wr_ok = cfg_we && !(&cfg_wdata);

   for (genvar g = 0; g < NUM_REQ; g++) begin : gen_slot
      logic [NUM_WAYS-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n) q <= '0;
         else if (wr_ok && slot_of(cfg_sel) == g) q <= cfg_wdata;
      end
      assign mask_all[g] = q;
   end

   assign cfg_rdata = mask_all[slot_of(cfg_sel)];
   assign req_mask  = mask_all[slot_of(req_id)];
endmodule

// File: rtl/cvs_pick.sv
module cvs_pick
   import cvs_pkg::*;
#(
   parameter int NUM_WAYS = 8,
   localparam int WAY_W   = $clog2(NUM_WAYS)
) (
   input  logic [NUM_WAYS-1:0] mask,
   input  logic [NUM_WAYS-1:0] valid,
   input  logic [NUM_WAYS-1:0] dirty,
   input  logic [NUM_WAYS-1:0] lock,
   input  logic [NUM_WAYS-1:0] used,
   output pick_e               reason,
   output logic [WAY_W-1:0]    way,
   output logic                way_dirty,
   output logic [NUM_WAYS-1:0] clr_mask
);
   logic [NUM_WAYS-1:0] elig;
   logic                f_inv, f_unu, f_any;
   logic [WAY_W-1:0]    i_inv, i_unu, i_any;

   assign elig = ~mask & ~lock;

   cvs_lowest #(.W(NUM_WAYS)) u_inv (.vec(elig & ~valid), .found(f_inv), .idx(i_inv));
   cvs_lowest #(.W(NUM_WAYS)) u_unu (.vec(elig & ~used),  .found(f_unu), .idx(i_unu));
   cvs_lowest #(.W(NUM_WAYS)) u_any (.vec(elig),          .found(f_any), .idx(i_any));

   always_comb begin
      clr_mask = '0;
      way      = '0;
      if (f_inv) begin
         reason = PICK_INVALID;
         way    = i_inv;
      end else if (f_unu) begin
         reason = PICK_UNUSED;
         way    = i_unu;
      end else if (f_any) begin
         reason   = PICK_SWEEP;
         way      = i_any;
         clr_mask = elig;
      end else begin
         reason = PICK_NONE;
      end
   end

   assign way_dirty = (reason != PICK_NONE) && valid[way] && dirty[way];
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel
   import cvs_pkg::*;
#(
   parameter int NUM_WAYS  = 8,
   parameter int NUM_CORES = 4,
   parameter int SET_BITS  = 6,
   parameter int PADDR_W   = 40,
   localparam int ID_W     = $clog2(NUM_CORES + 1),
   localparam int WAY_W    = $clog2(NUM_WAYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [ID_W-1:0]     cfg_sel,
   input  logic [NUM_WAYS-1:0] cfg_wdata,
   output logic [NUM_WAYS-1:0] cfg_rdata,
   input  logic                req_valid,
   input  logic [ID_W-1:0]     req_id,
   input  logic [PADDR_W-1:0]  req_paddr,
   input  logic [NUM_WAYS-1:0] way_valid,
   input  logic [NUM_WAYS-1:0] way_dirty,
   input  logic [NUM_WAYS-1:0] way_lock,
   input  logic [NUM_WAYS-1:0] way_use,
   output logic                out_valid,
   output logic [SET_BITS-1:0] set_index,
   output logic                victim_valid,
   output logic [WAY_W-1:0]    victim_way,
   output logic                victim_dirty,
   output logic                no_victim,
   output logic [NUM_WAYS-1:0] use_clr_mask
);
   if (NUM_WAYS < 2) begin : gen_chk_ways
      $error("NUM_WAYS must be at least 2");
   end
   if (NUM_CORES < 1) begin : gen_chk_cores
      $error("NUM_CORES must be at least 1");
   end
   if (LINE_SHIFT + SET_BITS > PADDR_W) begin : gen_chk_addr
      $error("set index does not fit in the address");
   end

   logic [NUM_WAYS-1:0] lookup_mask;
   pick_e               pk_reason;
   logic [WAY_W-1:0]    pk_way;
   logic                pk_dirty;
   logic [NUM_WAYS-1:0] pk_clr;

   cvs_mask_regs #(
      .NUM_WAYS(NUM_WAYS), .NUM_CORES(NUM_CORES), .ID_W(ID_W)
   ) u_masks (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .req_id(req_id), .req_mask(lookup_mask)
   );

   cvs_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
      .mask(lookup_mask), .valid(way_valid), .dirty(way_dirty),
      .lock(way_lock), .used(way_use), .reason(pk_reason),
      .way(pk_way), .way_dirty(pk_dirty), .clr_mask(pk_clr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         set_index    <= '0;
         victim_valid <= 1'b0;
         victim_way   <= '0;
         victim_dirty <= 1'b0;
         no_victim    <= 1'b0;
         use_clr_mask <= '0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            set_index    <= req_paddr[LINE_SHIFT +: SET_BITS];
            victim_valid <= (pk_reason != PICK_NONE);
            no_victim    <= (pk_reason == PICK_NONE);
            victim_way   <= pk_way;
            victim_dirty <= pk_dirty;
            use_clr_mask <= pk_clr;
         end
      end
   end
endmodule

// File: rtl/cvs_checker.sv
module cvs_checker #(
   parameter int NUM_WAYS = 8,
   parameter int WAY_W    = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [NUM_WAYS-1:0] lookup_mask,
   input logic [NUM_WAYS-1:0] way_lock,
   input logic [NUM_WAYS-1:0] cfg_rdata,
   input logic                out_valid,
   input logic                victim_valid,
   input logic [WAY_W-1:0]    victim_way,
   input logic                victim_dirty,
   input logic                no_victim,
   input logic [NUM_WAYS-1:0] use_clr_mask
);
   logic [NUM_WAYS-1:0] blk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) blk_q <= '0;
      else if (req_valid) blk_q <= lookup_mask | way_lock;
   end

   assert_victim_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && victim_valid) |-> !blk_q[victim_way]);

   assert_mask_not_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(&cfg_rdata));

   assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (victim_valid != no_victim));

   assert_clear_in_open_ways_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (use_clr_mask != '0)) |-> (victim_valid && ((use_clr_mask & blk_q) == '0)));

   assert_dirty_needs_victim_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && victim_dirty) |-> victim_valid);
endmodule

bind cache_victim_sel cvs_checker #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) i_cvs_checker (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .lookup_mask(lookup_mask),
   .way_lock(way_lock), .cfg_rdata(cfg_rdata), .out_valid(out_valid),
   .victim_valid(victim_valid), .victim_way(victim_way), .victim_dirty(victim_dirty),
   .no_victim(no_victim), .use_clr_mask(use_clr_mask)
);

// File: tb/test_cache_victim_sel.sv
`timescale 1ns/1ps
module test_cache_victim_sel;
   localparam int NW = 8;
   localparam int NC = 4;
   localparam int SB = 6;
   localparam int PW = 40;
   localparam int IDW = $clog2(NC + 1);
   localparam int WW = $clog2(NW);

   logic clk = 0, rst_n = 0;
   logic cfg_we = 0;
   logic [IDW-1:0] cfg_sel = '0;
   logic [NW-1:0] cfg_wdata = '0, cfg_rdata;
   logic req_valid = 0;
   logic [IDW-1:0] req_id = '0;
   logic [PW-1:0] req_paddr = '0;
   logic [NW-1:0] way_valid = '0, way_dirty = '0, way_lock = '0, way_use = '0;
   logic out_valid, victim_valid, victim_dirty, no_victim;
   logic [SB-1:0] set_index;
   logic [WW-1:0] victim_way;
   logic [NW-1:0] use_clr_mask;

   int checks = 0, fails = 0;
   logic [NW-1:0] model [NC+1];

   always #5 clk = ~clk;

   cache_victim_sel #(.NUM_WAYS(NW), .NUM_CORES(NC), .SET_BITS(SB), .PADDR_W(PW)) i_cache_victim_sel (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_id(req_id), .req_paddr(req_paddr),
      .way_valid(way_valid), .way_dirty(way_dirty), .way_lock(way_lock), .way_use(way_use),
      .out_valid(out_valid), .set_index(set_index), .victim_valid(victim_valid),
      .victim_way(victim_way), .victim_dirty(victim_dirty), .no_victim(no_victim),
      .use_clr_mask(use_clr_mask)
   );

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int slot(input logic [IDW-1:0] id);
      return (int'(id) < NC) ? int'(id) : NC;
   endfunction

   task automatic wr_mask(input logic [IDW-1:0] sel, input logic [NW-1:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 0;
      if (!(&d)) model[slot(sel)] = d;
      #1;
      chk((&d) ? "R3 reject" : "R2 write", 64'(cfg_rdata), 64'(model[slot(sel)]));
   endtask

   task automatic do_req(input string tag, input logic [IDW-1:0] id, input logic [PW-1:0] pa,
                         input logic [NW-1:0] v, input logic [NW-1:0] d,
                         input logic [NW-1:0] l, input logic [NW-1:0] u);
      logic [NW-1:0] el, ex_clr;
      int ex_way, kind;
      bit ex_dirty;
      el = ~model[slot(id)] & ~l;
      ex_way = 0; kind = 0; ex_clr = '0;
      for (int i = NW - 1; i >= 0; i--) if (el[i] && !v[i]) begin ex_way = i; kind = 1; end
      if (kind == 0)
         for (int i = NW - 1; i >= 0; i--) if (el[i] && !u[i]) begin ex_way = i; kind = 2; end
      if (kind == 0)
         for (int i = NW - 1; i >= 0; i--) if (el[i]) begin ex_way = i; kind = 3; end
      if (kind == 3) ex_clr = el;
      ex_dirty = (kind != 0) && v[ex_way] && d[ex_way];
      @(negedge clk);
      req_valid = 1; req_id = id; req_paddr = pa;
      way_valid = v; way_dirty = d; way_lock = l; way_use = u;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      chk({tag, " R10 out_valid"}, 64'(out_valid), 64'd1);
      chk({tag, " R10 set_index"}, 64'(set_index), 64'(pa[7 +: SB]));
      chk({tag, (kind == 0) ? " R8 victim_valid" : " R4 victim_valid"}, 64'(victim_valid), 64'(kind != 0));
      chk({tag, " R8 no_victim"}, 64'(no_victim), 64'(kind == 0));
      chk({tag, (kind == 1) ? " R5 way" : (kind == 2) ? " R6 way" : " R7 way"}, 64'(victim_way), 64'(ex_way));
      chk({tag, " R9 dirty"}, 64'(victim_dirty), 64'(ex_dirty));
      chk({tag, " R7 use_clr"}, 64'(use_clr_mask), 64'(ex_clr));
   endtask

   function automatic logic [NW-1:0] rbias(input int pct);
      logic [NW-1:0] r;
      for (int i = 0; i < NW; i++) r[i] = (($urandom % 100) < pct);
      return r;
   endfunction

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i <= NC; i++) model[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 out_valid", 64'(out_valid), 64'd0);
      chk("R1 victim_valid", 64'(victim_valid), 64'd0);
      chk("R1 no_victim", 64'(no_victim), 64'd0);
      chk("R1 use_clr", 64'(use_clr_mask), 64'd0);
      chk("R1 set_index", 64'(set_index), 64'd0);
      rst_n = 1;
      for (int i = 0; i <= NC; i++) begin
         cfg_sel = IDW'(i); #1;
         chk("R1 mask", 64'(cfg_rdata), 64'd0);
      end

      // directed
      do_req("invalid_first", 0, 40'h12_3456_7880, 8'hF3, 8'hFF, 8'h00, 8'h00);      // R5 way 2
      do_req("unused", 0, 40'h00_0000_1F80, 8'hFF, 8'h20, 8'h1F, 8'hFF & ~8'h60);     // R6 way 5, dirty
      do_req("sweep", 1, 40'h00_0000_0080, 8'hFF, 8'h08, 8'h01, 8'hFF);              // R7 way 1
      wr_mask(1, 8'hF0);
      wr_mask(1, 8'hFF);                                                            // R3 rejected
      do_req("core_mask", 1, 40'h0, 8'hFF, 8'h00, 8'h00, 8'hFF);                     // R2 way 0, clr 0F
      do_req("none", 1, 40'h0, 8'hFF, 8'hFF, 8'h0F, 8'hFF);                          // R8
      wr_mask(NC, 8'h7F);
      do_req("hw_mask", NC, 40'h0, 8'hFF, 8'hFF, 8'h00, 8'hFF);                      // R4 way 7
      do_req("hw_alias", 7, 40'h0, 8'h7F, 8'h00, 8'h00, 8'h00);                      // R2 id 7 uses hw mask
      do_req("hw_none", NC, 40'h0, 8'h00, 8'h00, 8'h80, 8'h00);                      // R8
      do_req("core0_open", 0, 40'h0, 8'h7F, 8'h00, 8'h00, 8'h00);                    // R4 way 7

      // random
      for (int n = 0; n < 400; n++) begin
         if (($urandom % 8) == 0)
            wr_mask(IDW'($urandom % 6), (($urandom % 4) == 0) ? '1 : rbias(60));
         do_req("rand", IDW'($urandom % 6), {$urandom, $urandom},
                rbias(90), rbias(50), rbias(25), rbias(85));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule